// File: doc/BRIEF.md
# Adaptive Idle-Timeout Shutdown Controller

This block watches a single activity input and counts how many consecutive clock cycles the system has been idle. When that count reaches the current timeout threshold it issues a one-cycle sleep request. While the system sleeps, the first active cycle produces a one-cycle wake request. The power state sequencing that follows these requests happens outside the block.

The threshold adapts to the workload. It starts at the break-even time, which limits energy use to twice that of a policy with perfect foresight. Each completed shutdown is then graded by the length of the whole idle run that contained it. A shutdown is graded "bad" when the run ended before the threshold plus the break-even time had passed. In that case the threshold rises by a fixed step, because the block is sleeping too readily. Any other shutdown is graded "good", and the threshold falls by the same step. The threshold always stays between a minimum and a maximum set by parameters. A threshold of zero gives the greedy policy, which sleeps on the first idle cycle.

Top module: `adaptive_idle_timeout`

## Requirements
- R1: After reset, `threshold_o` equals BREAK_EVEN (6 by default), both request outputs are low, and the block is awake.
- R2: While awake, when `active_i` is low at thr+1 consecutive rising edges (thr being `threshold_o`), `sleep_req_o` goes high after the (thr+1)-th of those edges for exactly one cycle. No further sleep request follows within the same idle run.
- R3: Any rising edge with `active_i` high clears the idle count. An idle run of thr edges or fewer therefore produces no sleep request, and `threshold_o` keeps its value.
- R4: While asleep, the first rising edge with `active_i` high makes `wake_req_o` high for exactly the following cycle. No wake request occurs without a preceding sleep.
- R5: Let L be the number of idle edges in the run that contained a shutdown. If L < thr + BREAK_EVEN, the shutdown is bad. `threshold_o` then rises by STEP in the same cycle as the wake request, but never above THR_MAX.
- R6: If L >= thr + BREAK_EVEN, the shutdown is good. `threshold_o` then falls by STEP in the same cycle as the wake request, but never below THR_MIN.
- R7: `threshold_o` changes only in a cycle where `wake_req_o` is high, and it always lies within [THR_MIN, THR_MAX].
- R8: With a threshold of 0, a sleep request follows the first idle edge (greedy policy).
- R9: The idle counter saturates at 2^CNT_W-1 and does not wrap. An idle run longer than that is graded as the saturated length.
- R10: `sleep_req_o` and `wake_req_o` are never high in the same cycle. A sleep request only follows an idle edge, and a wake request only follows an active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| active_i | input | 1 | High when the system is busy in this cycle |
| sleep_req_o | output | 1 | One-cycle request to enter the inactive state |
| wake_req_o | output | 1 | One-cycle request to leave the inactive state |
| threshold_o | output | CNT_W | Current timeout threshold in cycles |

## Verification
Every result passes through exactly one register. A sleep request is due in the cycle after the (thr+1)-th idle edge. The wake request and the new threshold are both due in the cycle after the first active edge. The bench drives `active_i` on falling edges and samples each output on the falling edge that follows the edge where it is due. It records the index of every sleep pulse within an idle run, so a pulse that comes early, comes late or repeats is caught. After each wake it also checks that the wake pulse has dropped one cycle later.

// File: rtl/adaptive_idle_timeout.sv
module adaptive_idle_timeout #(
  parameter int CNT_W      = 12,
  parameter int BREAK_EVEN = 6,
  parameter int STEP       = 2,
  parameter int THR_MIN    = 0,
  parameter int THR_MAX    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  output logic             sleep_req_o,
  output logic             wake_req_o,
  output logic [CNT_W-1:0] threshold_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W:0]   BE_W    = (CNT_W+1)'(BREAK_EVEN);
  localparam logic [CNT_W:0]   STEP_W  = (CNT_W+1)'(STEP);
  localparam logic [CNT_W:0]   MIN_W   = (CNT_W+1)'(THR_MIN);
  localparam logic [CNT_W:0]   MAX_W   = (CNT_W+1)'(THR_MAX);

  logic [CNT_W-1:0] idle_cnt, thr;
  logic             asleep;

  wire go_sleep = !asleep && !active_i && (idle_cnt >= thr);
  wire go_wake  = asleep && active_i;

  wire [CNT_W:0] thr_w    = {1'b0, thr};
  wire           bad_shut = {1'b0, idle_cnt} < (thr_w + BE_W);
  wire [CNT_W:0] thr_up   = thr_w + STEP_W;
  wire [CNT_W-1:0] thr_inc = (thr_up > MAX_W) ? MAX_W[CNT_W-1:0] : thr_up[CNT_W-1:0];
  wire [CNT_W-1:0] thr_dec = (thr_w < MIN_W + STEP_W) ? MIN_W[CNT_W-1:0]
                                                       : thr - STEP_W[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt    <= '0;
      thr         <= CNT_W'(BREAK_EVEN);
      asleep      <= 1'b0;
      sleep_req_o <= 1'b0;
      wake_req_o  <= 1'b0;
    end else begin
      sleep_req_o <= go_sleep;
      wake_req_o  <= go_wake;
      if (active_i)                 idle_cnt <= '0;
      else if (idle_cnt != CNT_SAT) idle_cnt <= idle_cnt + 1'b1;
      if (go_sleep)     asleep <= 1'b1;
      else if (go_wake) asleep <= 1'b0;
      if (go_wake) thr <= bad_shut ? thr_inc : thr_dec;
    end
  end

  assign threshold_o = thr;

  // R10
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_req_o && wake_req_o));

  // R2
  sleep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req_o |=> !sleep_req_o);

  // R4
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o);

  // R10
  sleep_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req_o) |-> !$past(active_i));

  // R10
  wake_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> $past(active_i));

  // R7
  thr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(threshold_o) |-> wake_req_o);

  // R7
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold_o >= MIN_W[CNT_W-1:0]) && (threshold_o <= MAX_W[CNT_W-1:0]));

endmodule

// File: tb/adaptive_idle_timeout_bench.sv
module adaptive_idle_timeout_bench;
  localparam int CNT_W = 12, BE = 6, STEP = 2, TMIN = 0, TMAX = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active_i = 1'b1;
  logic sleep_req_o, wake_req_o;
  logic [CNT_W-1:0] threshold_o;

  int n_tests = 0, n_fail = 0;
  int exp_thr = BE;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adaptive_idle_timeout #(.CNT_W(CNT_W), .BREAK_EVEN(BE), .STEP(STEP),
    .THR_MIN(TMIN), .THR_MAX(TMAX)) u_adaptive_idle_timeout (
    .clk(clk), .rst_n(rst_n), .active_i(active_i),
    .sleep_req_o(sleep_req_o), .wake_req_o(wake_req_o), .threshold_o(threshold_o));

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Idle for L edges starting from an awake, active state, then wake.
  task automatic idle_run(int L, string req);
    int pulses = 0, idx = -1;
    bit slept = (L >= exp_thr + 1);
    bit bad = (L < exp_thr + BE);
    @(negedge clk);
    active_i = 1'b0;
    for (int i = 1; i <= L; i++) begin
      @(negedge clk);
      if (sleep_req_o) begin pulses++; if (idx < 0) idx = i; end
    end
    chk(pulses == (slept ? 1 : 0), {req, " sleep count"}, pulses, slept ? 1 : 0);
    if (slept) chk(idx == exp_thr + 1, {req, " sleep edge"}, idx, exp_thr + 1);
    active_i = 1'b1;
    @(negedge clk);
    if (slept) begin
      if (bad) exp_thr = (exp_thr + STEP > TMAX) ? TMAX : exp_thr + STEP;
      else     exp_thr = (exp_thr - STEP < TMIN) ? TMIN : exp_thr - STEP;
    end
    chk(wake_req_o == slept, {req, " wake"}, wake_req_o, slept);
    chk(threshold_o == exp_thr, {req, " threshold"}, threshold_o, exp_thr);
    @(negedge clk);
    chk(wake_req_o == 1'b0, {req, " wake pulse width R4"}, wake_req_o, 0);
  endtask

  task automatic t_reset();
    chk(threshold_o == BE, "R1 threshold", threshold_o, BE);
    chk(!sleep_req_o && !wake_req_o, "R1 requests", {sleep_req_o, wake_req_o}, 0);
  endtask

  task automatic t_short_idle();
    idle_run(4, "R3 short idle");
    idle_run(4, "R3 counter cleared");
  endtask

  task automatic t_bad();
    idle_run(8, "R5 bad");
    idle_run(10, "R5 bad");
    idle_run(12, "R5 bad");
    idle_run(14, "R7 clamp max");
  endtask

  task automatic t_good();
    for (int k = 0; k < 7; k++) idle_run(30, "R6 good / R7 clamp min");
  endtask

  task automatic t_greedy();
    chk(threshold_o == 0, "R8 zero threshold", threshold_o, 0);
    idle_run(1, "R8 greedy");
  endtask

  task automatic t_saturate();
    idle_run(4098, "R9 saturation");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_idle();
    t_bad();
    t_good();
    t_greedy();
    t_saturate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule